// File: doc/BRIEF.md
# Tester Channel Card: Per-Pin Pattern Drive and Capture

This block holds one card's worth of digital tester channels. Every pin owns a pattern memory and a direction bit. A pin set to drive puts its stored bit on the stimulus output at each stimulus strobe and has its output enable asserted. A pin set to receive keeps its driver disabled and, at each write strobe, stores the comparator result into its own memory. So one memory bit holds either a stimulus or a captured response, depending on that pin's direction.

The pins are banked into two halves of twelve. A host port selects a half and an address, then loads or reads back twelve bits at a time. It also writes the twelve direction bits of a half. Host loads are refused while a test is running. The pattern address, the two strobes and the run flag come from an external timing generator. Each half stores its memory as words that are twelve bits wide.

Top module: `tester_channel_card`

## Requirements
- R1: While reset is held and right after it, every output enable is 0, every drive output is 0 and host_rvalid_o is 0.
- R2: With test_run_i low, host_dir_wr_i writes host_wdata_i into the direction bits of the half chosen by host_sel_i (1 = drive, 0 = receive). drv_en_o shows the new value from the next cycle, and the other half is left unchanged.
- R3: With test_run_i low, host_mem_wr_i stores host_wdata_i at host_addr_i in the selected half. A host_rd_i for that half and address returns the stored word on host_rdata_o in the next cycle.
- R4: While test_run_i is high, host_mem_wr_i and host_dir_wr_i have no effect on memory contents or directions.
- R5: With test_run_i high, stim_stb_i loads the word at pat_addr_i. From the next cycle each drive pin shows its bit on drv_o, and it holds that value until the next accepted stimulus strobe.
- R6: A receive pin always has drv_en_o = 0 and drv_o = 0.
- R7: With test_run_i high, wr_stb_i writes cmp_i into the receive pins' bits at pat_addr_i. The bits of drive pins at that address stay unchanged. A cmp_i bit of 1 means the device level was above the reference.
- R8: With test_run_i low, stim_stb_i and wr_stb_i are ignored.
- R9: Half 0 (host_sel_i = 0) covers pins 1 to 12 on port bits 0 to 11. Half 1 covers pins 13 to 24 on port bits 12 to 23. host_wdata_i and host_rdata_o bit k belongs to the k-th pin of the selected half.
- R10: host_rvalid_o is 1 exactly in the cycle after a cycle with host_rd_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pattern clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_run_i | input | 1 | Test running: enables strobes, blocks host loads |
| pat_addr_i | input | 8 | Pattern step address from the timing generator |
| stim_stb_i | input | 1 | Stimulus strobe |
| wr_stb_i | input | 1 | Response write strobe |
| cmp_i | input | 24 | Comparator results, one per pin |
| drv_o | output | 24 | Driver data, one per pin |
| drv_en_o | output | 24 | Driver output enable, one per pin |
| host_sel_i | input | 1 | Half-card select |
| host_addr_i | input | 8 | Host memory address |
| host_wdata_i | input | 12 | Host write data for one half |
| host_mem_wr_i | input | 1 | Host memory write |
| host_dir_wr_i | input | 1 | Host direction write |
| host_rd_i | input | 1 | Host memory read request |
| host_rdata_o | output | 12 | Read-back word |
| host_rvalid_o | output | 1 | Read-back valid |

## Verification
A wrong stored bit cannot be seen until something reads it. It appears on drv_o one cycle after the stimulus strobe that addresses it, or on host_rdata_o one cycle after a read of that address. For that reason the bench fills every address of both halves and reads every one back, both after loading and after capture. A corrupt direction bit appears on drv_en_o in the very next cycle. It also appears as a merge error in the captured words, where a drive bit would be overwritten or a receive bit kept.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic {
    DIR_RECV  = 1'b0,
    DIR_DRIVE = 1'b1
  } pin_dir_e;
endpackage

// File: rtl/tcc_half_bank.sv
module tcc_half_bank #(
  parameter int unsigned PINS  = 12,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [AW-1:0]   pat_addr_i,
  input  logic            stim_stb_i,
  input  logic            wr_stb_i,
  input  logic [PINS-1:0] cmp_i,
  input  logic            sel_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [PINS-1:0] host_wdata_i,
  input  logic            host_mem_wr_i,
  input  logic            host_dir_wr_i,
  input  logic            host_rd_i,
  output logic [PINS-1:0] drv_o,
  output logic [PINS-1:0] drv_en_o,
  output logic [PINS-1:0] rdata_o
);
  import tcc_pkg::*;

  logic [PINS-1:0] mem_q [DEPTH];
  logic [PINS-1:0] dir_q, drv_q, rdata_q;
  logic            host_ok, cap_en, stim_en;

  assign host_ok = sel_i && !run_i;
  assign cap_en  = run_i && wr_stb_i;
  assign stim_en = run_i && stim_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= '0;
    else if (host_ok && host_dir_wr_i) dir_q <= host_wdata_i;
  end

  // receive bits take the comparator, drive bits keep their stimulus
  always_ff @(posedge clk_i) begin
    if (host_ok && host_mem_wr_i)
      mem_q[host_addr_i] <= host_wdata_i;
    else if (cap_en)
      mem_q[pat_addr_i] <= (mem_q[pat_addr_i] & dir_q) | (cmp_i & ~dir_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= '0;
    else if (stim_en) drv_q <= mem_q[pat_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (sel_i && host_rd_i) rdata_q <= mem_q[host_addr_i];
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_comb begin
      drv_en_o[p] = (dir_q[p] == DIR_DRIVE);
      drv_o[p]    = (dir_q[p] == DIR_DRIVE) ? drv_q[p] : 1'b0;
    end
  end

  assign rdata_o = rdata_q;

  // R4
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(dir_q));

  // R5
  drv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && stim_stb_i) |=> $stable(drv_q));
endmodule

// File: rtl/tcc_read_mux.sv
module tcc_read_mux #(
  parameter int unsigned HALVES = 2,
  parameter int unsigned W      = 12,
  parameter int unsigned SW     = 1
) (
  input  logic [HALVES*W-1:0] rdata_all_i,
  input  logic [SW-1:0]       sel_i,
  output logic [W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int h = 0; h < HALVES; h++)
      if (sel_i == SW'(h)) rdata_o = rdata_all_i[h*W +: W];
  end
endmodule

// File: rtl/tester_channel_card.sv
module tester_channel_card #(
  parameter int unsigned HALF_PINS  = 12,
  parameter int unsigned NUM_HALVES = 2,
  parameter int unsigned DEPTH      = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PINS = HALF_PINS * NUM_HALVES,
  localparam int unsigned SW   = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 test_run_i,
  input  logic [AW-1:0]        pat_addr_i,
  input  logic                 stim_stb_i,
  input  logic                 wr_stb_i,
  input  logic [PINS-1:0]      cmp_i,
  output logic [PINS-1:0]      drv_o,
  output logic [PINS-1:0]      drv_en_o,
  input  logic [SW-1:0]        host_sel_i,
  input  logic [AW-1:0]        host_addr_i,
  input  logic [HALF_PINS-1:0] host_wdata_i,
  input  logic                 host_mem_wr_i,
  input  logic                 host_dir_wr_i,
  input  logic                 host_rd_i,
  output logic [HALF_PINS-1:0] host_rdata_o,
  output logic                 host_rvalid_o
);
  logic [PINS-1:0] rdata_all;
  logic [SW-1:0]   rd_sel_q;
  logic            rvalid_q;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    tcc_half_bank #(.PINS(HALF_PINS), .DEPTH(DEPTH)) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .run_i        (test_run_i),
      .pat_addr_i   (pat_addr_i),
      .stim_stb_i   (stim_stb_i),
      .wr_stb_i     (wr_stb_i),
      .cmp_i        (cmp_i[h*HALF_PINS +: HALF_PINS]),
      .sel_i        (host_sel_i == SW'(h)),
      .host_addr_i  (host_addr_i),
      .host_wdata_i (host_wdata_i),
      .host_mem_wr_i(host_mem_wr_i),
      .host_dir_wr_i(host_dir_wr_i),
      .host_rd_i    (host_rd_i),
      .drv_o        (drv_o[h*HALF_PINS +: HALF_PINS]),
      .drv_en_o     (drv_en_o[h*HALF_PINS +: HALF_PINS]),
      .rdata_o      (rdata_all[h*HALF_PINS +: HALF_PINS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sel_q <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_rd_i;
      if (host_rd_i) rd_sel_q <= host_sel_i;
    end
  end

  tcc_read_mux #(.HALVES(NUM_HALVES), .W(HALF_PINS), .SW(SW)) u_rmux (
    .rdata_all_i(rdata_all),
    .sel_i      (rd_sel_q),
    .rdata_o    (host_rdata_o)
  );

  assign host_rvalid_o = rvalid_q;

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (drv_en_o == '0 && drv_o == '0 && !host_rvalid_o);
    end
  end

  // R10
  rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i |=> host_rvalid_o);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> !host_rvalid_o);

  // R2
  dir_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drv_en_o) |-> ($past(host_dir_wr_i) && !$past(test_run_i)));
endmodule

// File: tb/tester_channel_card_bench.sv
module tester_channel_card_bench;
  localparam int HP = 12;
  localparam int NH = 2;
  localparam int D  = 256;
  localparam int P  = HP * NH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic [7:0]    pat_addr = '0;
  logic          stim_stb = 1'b0, wr_stb = 1'b0;
  logic [P-1:0]  cmp = '0;
  logic [P-1:0]  drv, drv_en;
  logic          hsel = 1'b0;
  logic [7:0]    haddr = '0;
  logic [HP-1:0] hwdata = '0;
  logic          hmem_wr = 1'b0, hdir_wr = 1'b0, hrd = 1'b0;
  logic [HP-1:0] hrdata;
  logic          hrvalid;

  int n_chk = 0, n_fail = 0;
  logic [HP-1:0] model [NH][D];
  logic [HP-1:0] dir_m [NH];

  always #2 clk = ~clk;

  tester_channel_card u_tester_channel_card (
    .clk_i(clk), .rst_ni(rst_n), .test_run_i(run), .pat_addr_i(pat_addr),
    .stim_stb_i(stim_stb), .wr_stb_i(wr_stb), .cmp_i(cmp),
    .drv_o(drv), .drv_en_o(drv_en),
    .host_sel_i(hsel), .host_addr_i(haddr), .host_wdata_i(hwdata),
    .host_mem_wr_i(hmem_wr), .host_dir_wr_i(hdir_wr), .host_rd_i(hrd),
    .host_rdata_o(hrdata), .host_rvalid_o(hrvalid)
  );

  function automatic logic [HP-1:0] pat(int h, int a);
    return HP'((a * 37 + h * 613 + 11) ^ (a << 4));
  endfunction

  function automatic logic [P-1:0] capt(int a);
    return P'((a * 2654435 + 97) ^ (a << 12));
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [P-1:0] act, input logic [P-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int h, input int a, input logic [HP-1:0] d, input bit dir);
    @(negedge clk);
    hsel = h[0]; haddr = 8'(a); hwdata = d;
    hmem_wr = !dir; hdir_wr = dir;
    @(negedge clk);
    hmem_wr = 1'b0; hdir_wr = 1'b0;
  endtask

  task automatic host_rd(input int h, input int a, output logic [HP-1:0] d, output logic v);
    @(negedge clk);
    hsel = h[0]; haddr = 8'(a); hrd = 1'b1;
    @(negedge clk);
    hrd = 1'b0; d = hrdata; v = hrvalid;
  endtask

  task automatic strobe(input int a, input bit stim, input logic [P-1:0] c);
    @(negedge clk);
    pat_addr = 8'(a); stim_stb = stim; wr_stb = !stim; cmp = c;
    @(negedge clk);
    stim_stb = 1'b0; wr_stb = 1'b0;
  endtask

  function automatic logic [P-1:0] exp_drv(int a);
    return {model[1][a] & dir_m[1], model[0][a] & dir_m[0]};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [HP-1:0] d;
    logic v;
    logic [P-1:0] held;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(drv_en == '0 && drv == '0 && !hrvalid, "R1", drv_en, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(drv_en == '0 && drv == '0 && !hrvalid, "R1", drv, '0);

    // R3 R9: load and read back every word of both halves
    for (int h = 0; h < NH; h++)
      for (int a = 0; a < D; a++) begin
        host_wr(h, a, pat(h, a), 1'b0);
        model[h][a] = pat(h, a);
      end
    for (int h = 0; h < NH; h++)
      for (int a = 0; a < D; a++) begin
        host_rd(h, a, d, v);
        check(v && d == model[h][a], "R3", P'(d), P'(model[h][a]));
      end
    // R10: no request, no valid
    @(negedge clk);
    check(!hrvalid, "R10", P'(hrvalid), '0);

    // R2 R9: per-half directions
    dir_m[0] = 12'hA5C; dir_m[1] = 12'h3F0;
    host_wr(0, 0, dir_m[0], 1'b1);
    check(drv_en == {12'h000, dir_m[0]}, "R2", drv_en, {12'h000, dir_m[0]});
    host_wr(1, 0, dir_m[1], 1'b1);
    check(drv_en == {dir_m[1], dir_m[0]}, "R9", drv_en, {dir_m[1], dir_m[0]});

    // R8: strobes without run
    strobe(9, 1'b1, '0);
    check(drv == '0, "R8", drv, '0);
    strobe(9, 1'b0, '1);
    host_rd(0, 9, d, v);
    check(d == model[0][9], "R8", P'(d), P'(model[0][9]));

    // R4: host loads blocked during run
    run = 1'b1;
    host_wr(0, 7, ~model[0][7], 1'b0);
    host_wr(0, 0, 12'h000, 1'b1);
    check(drv_en == {dir_m[1], dir_m[0]}, "R4", drv_en, {dir_m[1], dir_m[0]});
    host_rd(0, 7, d, v);
    check(d == model[0][7], "R4", P'(d), P'(model[0][7]));

    // R5 R6: stimulus over every address
    for (int a = 0; a < D; a++) begin
      strobe(a, 1'b1, '0);
      check(drv == exp_drv(a), "R5", drv, exp_drv(a));
    end
    held = drv;
    repeat (2) @(negedge clk);
    check(drv == held, "R5", drv, held);

    // R7: capture over every address, receive bits only
    for (int a = 0; a < D; a++) begin
      strobe(a, 1'b0, capt(a));
      for (int h = 0; h < NH; h++)
        model[h][a] = (model[h][a] & dir_m[h]) | (capt(a)[h*HP +: HP] & ~dir_m[h]);
    end
    run = 1'b0;
    for (int h = 0; h < NH; h++)
      for (int a = 0; a < D; a++) begin
        host_rd(h, a, d, v);
        check(d == model[h][a], "R7", P'(d), P'(model[h][a]));
      end

    // R6: whole half to receive
    dir_m[1] = '0;
    host_wr(1, 0, 12'h000, 1'b1);
    check(drv[23:12] == '0 && drv_en[23:12] == '0, "R6", {drv[23:12], drv_en[23:12]}, '0);
    check(drv == exp_drv(D - 1), "R6", drv, exp_drv(D - 1));

    finish_run();
  end
endmodule